// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is the serial-bus front end of an on-chip temperature monitor. It listens to a two-wire bus (I2C framing: START, 7-bit address plus direction bit, byte-wise acknowledge, STOP) and gives the bus access to four internal registers. A pointer byte chooses the register. The pointer keeps its value after the transaction ends, so a host that polls the same register again can send only the address and read the data. The registers hold the temperature, which comes in from the sensing logic, a one-byte configuration, and a low and a high limit of two bytes each. The configuration and the limits leave the block on plain ports for the comparison logic.

SCL and SDA are oversampled on the system clock through a synchronizer, so the slave works on edges it has detected and not on the raw pins. The slave only ever pulls SDA low. The block also holds two alert flags, an interrupt flag and a critical flag. The comparison logic sets them with single-cycle event pulses. A read in interrupt mode clears the interrupt flag, and entering shutdown clears both flags.

Top module: `tsens_i2c_slave`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits equal the parameter DEV_ADDR. On any other address it leaves SDA released on the acknowledge clock and ignores the rest of the transaction until the next START.
- R2: After reset the pointer is 0. The pointer keeps the last value written to it across transactions. Only bits 1:0 of a pointer byte are used, so 0x06 selects register 2. A read that begins directly with the address returns the register at the latched pointer.
- R3: Pointer values select the registers: 0 temperature (temp_i), 1 configuration, 2 low limit, 3 high limit. A write to register 0 is acknowledged and changes nothing.
- R4: The configuration register takes the first data byte of a write. A limit register takes two data bytes, upper byte first, and changes only when the second byte is acknowledged. Further data bytes are acknowledged and ignored.
- R5: Read data leaves the slave bit 7 first. A two-byte register sends its upper byte, then its lower byte, and alternates while the master keeps acknowledging. The configuration register repeats its single byte. The 16-bit value is captured when the first byte is loaded, so a change of temp_i during the read does not mix two samples.
- R6: A master acknowledge (SDA low) after a read byte makes the slave send the next byte. A NACK makes it release SDA and return to idle.
- R7: A write of the address and a pointer byte, followed by a repeated START and a read address, returns data from the newly set pointer.
- R8: The slave changes its SDA drive only while the synchronized SCL is low, or on a START or STOP. A START or STOP returns it to address reception or to idle with SDA released.
- R9: Configuration bit 1 selects interrupt mode. In interrupt mode, acknowledging a read address clears int_o. When bit 1 is 0, reads leave int_o unchanged.
- R10: Configuration bit 0 is shutdown. A write that changes it from 0 to 1 clears int_o and crit_o. While shutdown is set, event pulses do not set either flag.
- R11: A one-cycle pulse on int_evt_i sets int_o, and a pulse on crit_evt_i sets crit_o. Each flag stays set until one of the clear conditions in R9 or R10 occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |
| temp_i | input | 16 | Current temperature word from the sensing logic |
| int_evt_i | input | 1 | Single-cycle pulse that sets the interrupt flag |
| crit_evt_i | input | 1 | Single-cycle pulse that sets the critical flag |
| cfg_o | output | 8 | Configuration register (bit 0 shutdown, bit 1 interrupt mode) |
| tlow_o | output | 16 | Low limit register |
| thigh_o | output | 16 | High limit register |
| int_o | output | 1 | Interrupt alert flag |
| crit_o | output | 1 | Critical alert flag |

## Verification
The bench builds the slave with DEV_ADDR set to 7'h4B rather than the default, so a design that ignores the parameter is caught. The mismatch case uses an address that differs from it in one bit. SYNC_STAGES stays at 2 and the bench holds every bus phase for six clocks. That covers the three-clock lag from pin to detected edge, while the acknowledge and first-data-bit hand-over still happens in the same SCL low period as the master's next drive. Because of this, repeated STARTs, early STOPs and back-to-back acknowledges all reach the slave at the edge spacings it sees on a real bus.

// File: rtl/tsens_i2c_pkg.sv
package tsens_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int PTR_W  = 2;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [PTR_W-1:0] SEL_TEMP = 2'd0;
    localparam logic [PTR_W-1:0] SEL_CFG  = 2'd1;
    localparam logic [PTR_W-1:0] SEL_LOW  = 2'd2;
    localparam logic [PTR_W-1:0] SEL_HIGH = 2'd3;

    typedef enum logic [3:0] {
        LK_IDLE,
        LK_ADDR,
        LK_AACK,
        LK_PTR,
        LK_PACK,
        LK_WDAT,
        LK_WACK,
        LK_RDAT,
        LK_RACK
    } link_state_t;

    typedef struct packed {
        logic               en;
        logic [PTR_W-1:0]   sel;
        logic [1:0]         idx;
        logic [BYTE_W-1:0]  data;
    } wr_req_t;

    function automatic logic reg_is_wide(input logic [PTR_W-1:0] sel);
        return sel != SEL_CFG;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] word,
                                                    input logic wide,
                                                    input logic lower);
        if (wide && !lower) return word[WORD_W-1:BYTE_W];
        return word[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/tsens_i2c_sync.sv
module tsens_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q[g] <= 1'b1;
                    sda_q[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_q[g] <= scl_i;
                    sda_q[g] <= sda_i;
                end else begin
                    scl_q[g] <= scl_q[(g == 0) ? 0 : g-1];
                    sda_q[g] <= sda_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tsens_i2c_regs.sv
module tsens_i2c_regs
    import tsens_i2c_pkg::*;
#(
    parameter logic [WORD_W-1:0] LOW_RST  = '0,
    parameter logic [WORD_W-1:0] HIGH_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic              rd_clr,
    input  logic [PTR_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_word,
    input  logic [WORD_W-1:0] temp_i,
    input  logic              int_evt_i,
    input  logic              crit_evt_i,
    output logic [BYTE_W-1:0] cfg_o,
    output logic [WORD_W-1:0] tlow_o,
    output logic [WORD_W-1:0] thigh_o,
    output logic              int_o,
    output logic              crit_o
);
    logic [BYTE_W-1:0] hold;
    logic              shut_entry;
    logic              cfg_wr;

    assign cfg_wr     = wr.en && (wr.sel == SEL_CFG) && (wr.idx == 2'd0);
    assign shut_entry = cfg_wr && wr.data[0] && !cfg_o[0];

    always_comb begin
        unique case (rd_sel)
            SEL_TEMP: rd_word = temp_i;
            SEL_CFG:  rd_word = {{(WORD_W-BYTE_W){1'b0}}, cfg_o};
            SEL_LOW:  rd_word = tlow_o;
            default:  rd_word = thigh_o;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o   <= '0;
            tlow_o  <= LOW_RST;
            thigh_o <= HIGH_RST;
            hold    <= '0;
        end else if (wr.en) begin
            if (cfg_wr) cfg_o <= wr.data;
            if (reg_is_wide(wr.sel) && wr.sel != SEL_TEMP) begin
                if (wr.idx == 2'd0) hold <= wr.data;
                if (wr.idx == 2'd1) begin
                    if (wr.sel == SEL_LOW) tlow_o  <= {hold, wr.data};
                    else                   thigh_o <= {hold, wr.data};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_o  <= 1'b0;
            crit_o <= 1'b0;
        end else begin
            if (shut_entry || (rd_clr && cfg_o[1])) int_o <= 1'b0;
            else if (int_evt_i && !cfg_o[0])        int_o <= 1'b1;
            if (shut_entry)                         crit_o <= 1'b0;
            else if (crit_evt_i && !cfg_o[0])       crit_o <= 1'b1;
        end
    end
endmodule

// File: rtl/tsens_i2c_link.sv
module tsens_i2c_link
    import tsens_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [WORD_W-1:0] rd_word,
    output logic [PTR_W-1:0]  ptr,
    output wr_req_t           wr,
    output logic              rd_clr,
    output logic              sda_oe,
    output logic              idle
);
    link_state_t       st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic [WORD_W-1:0] snap;
    logic              wide;
    logic              rw;
    logic              mack;
    logic [1:0]        idx;
    logic [BYTE_W-1:0] first_b;
    logic [BYTE_W-1:0] next_b;
    logic              byte_done;

    assign idle      = (st == LK_IDLE);
    assign byte_done = (cnt == CNT_W'(BYTE_W));
    assign first_b   = pick_byte(rd_word, reg_is_wide(ptr), 1'b0);
    assign next_b    = pick_byte(snap, wide, ~idx[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= LK_IDLE; cnt <= '0; sh <= '0; tx <= '0; snap <= '0;
            wide <= 1'b0; rw <= 1'b0; mack <= 1'b0; idx <= '0;
            ptr <= SEL_TEMP; sda_oe <= 1'b0; wr <= '0; rd_clr <= 1'b0;
        end else begin
            wr.en  <= 1'b0;
            rd_clr <= 1'b0;
            if (start_det) begin
                st <= LK_ADDR; cnt <= '0; sda_oe <= 1'b0;
            end else if (stop_det) begin
                st <= LK_IDLE; sda_oe <= 1'b0;
            end else begin
                if (scl_rise) begin
                    unique case (st)
                        LK_ADDR, LK_PTR, LK_WDAT: begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end
                        LK_RDAT: cnt <= cnt + 1'b1;
                        LK_RACK: mack <= ~sda_s;
                        default: ;
                    endcase
                end
                if (scl_fall) begin
                    unique case (st)
                        LK_ADDR: if (byte_done) begin
                            cnt <= '0;
                            if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                                st <= LK_AACK; sda_oe <= 1'b1; rw <= sh[0];
                                rd_clr <= sh[0];
                            end else begin
                                st <= LK_IDLE;
                            end
                        end
                        LK_AACK: begin
                            cnt <= '0;
                            if (rw) begin
                                st <= LK_RDAT; idx <= '0; snap <= rd_word;
                                wide <= reg_is_wide(ptr); tx <= first_b;
                                sda_oe <= ~first_b[BYTE_W-1];
                            end else begin
                                st <= LK_PTR; sda_oe <= 1'b0;
                            end
                        end
                        LK_PTR: if (byte_done) begin
                            ptr <= sh[PTR_W-1:0]; st <= LK_PACK;
                            sda_oe <= 1'b1; cnt <= '0;
                        end
                        LK_PACK: begin
                            st <= LK_WDAT; sda_oe <= 1'b0; idx <= '0;
                        end
                        LK_WDAT: if (byte_done) begin
                            st <= LK_WACK; sda_oe <= 1'b1; cnt <= '0;
                            wr <= '{en: 1'b1, sel: ptr, idx: idx, data: sh};
                        end
                        LK_WACK: begin
                            st <= LK_WDAT; sda_oe <= 1'b0;
                            if (idx != 2'd2) idx <= idx + 1'b1;
                        end
                        LK_RDAT: begin
                            if (byte_done) begin
                                st <= LK_RACK; sda_oe <= 1'b0; cnt <= '0;
                            end else begin
                                sda_oe <= ~tx[3'(BYTE_W-1) - cnt[2:0]];
                            end
                        end
                        LK_RACK: begin
                            if (mack) begin
                                st <= LK_RDAT; idx <= idx + 1'b1; tx <= next_b;
                                sda_oe <= ~next_b[BYTE_W-1]; cnt <= '0;
                            end else begin
                                st <= LK_IDLE; sda_oe <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/tsens_i2c_slave.sv
module tsens_i2c_slave
    import tsens_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [15:0] temp_i,
    input  logic        int_evt_i,
    input  logic        crit_evt_i,
    output logic [7:0]  cfg_o,
    output logic [15:0] tlow_o,
    output logic [15:0] thigh_o,
    output logic        int_o,
    output logic        crit_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [PTR_W-1:0]  ptr;
    logic [WORD_W-1:0] rd_word;
    wr_req_t           wr;
    logic              rd_clr;
    logic              link_idle;
    logic              wr_en;

    assign wr_en = wr.en;

    tsens_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tsens_i2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_word(rd_word), .ptr(ptr), .wr(wr), .rd_clr(rd_clr),
        .sda_oe(sda_oe_o), .idle(link_idle)
    );

    tsens_i2c_regs u_regs (
        .clk(clk), .rst(rst), .wr(wr), .rd_clr(rd_clr), .rd_sel(ptr),
        .rd_word(rd_word), .temp_i(temp_i), .int_evt_i(int_evt_i),
        .crit_evt_i(crit_evt_i), .cfg_o(cfg_o), .tlow_o(tlow_o),
        .thigh_o(thigh_o), .int_o(int_o), .crit_o(crit_o)
    );
endmodule

// File: rtl/tsens_i2c_slave_chk.sv
module tsens_i2c_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        sda_oe_o,
    input logic        scl_s,
    input logic        start_det,
    input logic        stop_det,
    input logic        link_idle,
    input logic        wr_en,
    input logic [7:0]  cfg_o,
    input logic [15:0] tlow_o,
    input logic [15:0] thigh_o,
    input logic        int_o,
    input logic        crit_o
);
    // R8: drive changes only while SCL low or on START/STOP
    p_sda_change_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> (!$past(scl_s) || $past(stop_det) || $past(start_det)));

    // R8: idle link never pulls the line
    p_idle_released_r8: assert property (@(posedge clk) disable iff (rst)
        link_idle |-> !sda_oe_o);

    // R4: register outputs move only after a write request
    p_regs_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable({cfg_o, tlow_o, thigh_o}));

    // R10: entering shutdown leaves both flags clear
    p_shutdown_clears_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_o[0]) |-> (!int_o && !crit_o));

    // R10: no flag rises while shutdown was already set
    p_shutdown_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_o[0]) |-> (!$rose(int_o) && !$rose(crit_o)));
endmodule

bind tsens_i2c_slave tsens_i2c_slave_chk u_chk (
    .clk(clk), .rst(rst), .sda_oe_o(sda_oe_o), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .link_idle(link_idle),
    .wr_en(wr_en), .cfg_o(cfg_o), .tlow_o(tlow_o), .thigh_o(thigh_o),
    .int_o(int_o), .crit_o(crit_o)
);

// File: tb/tsens_i2c_slave_bench.sv
module tsens_i2c_slave_bench;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 6;
    localparam logic [6:0] ADDR       = 7'h4B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [15:0] temp = 16'h1234;
    logic        int_evt = 1'b0, crit_evt = 1'b0;
    logic [7:0]  cfg;
    logic [15:0] tlow, thigh;
    logic        int_f, crit_f;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] m_cfg = 8'h00;
    logic [15:0] m_lo = 16'h0, m_hi = 16'h0;
    logic [7:0] rb [3];
    logic ak;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsens_i2c_slave #(.DEV_ADDR(ADDR), .SYNC_STAGES(2)) u_tsens_i2c_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .temp_i(temp), .int_evt_i(int_evt), .crit_evt_i(crit_evt),
        .cfg_o(cfg), .tlow_o(tlow), .thigh_o(thigh), .int_o(int_f), .crit_o(crit_f)
    );

    function automatic logic [7:0] exp_byte(input logic [15:0] w, input bit wide, input int i);
        if (!wide) return w[7:0];
        return (i % 2 == 0) ? w[15:8] : w[7:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic put_bit(input logic b, output logic seen);
        sda_m = b; wq(Q); scl = 1'b1; wq(Q);
        seen = sda_line; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(b[i], s);
        put_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic get_byte(input bit master_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, s);
            b[i] = s;
        end
        put_bit(~master_ack, s);
    endtask

    task automatic wr_reg(input logic [7:0] p, input int n, input logic [15:0] d);
        logic a;
        bus_start();
        put_byte({ADDR, 1'b0}, a);
        put_byte(p, a);
        if (n == 1) put_byte(d[7:0], a);
        if (n >= 2) begin put_byte(d[15:8], a); put_byte(d[7:0], a); end
        bus_stop();
    endtask

    task automatic rd_direct(input int n);
        logic a;
        bus_start();
        put_byte({ADDR, 1'b1}, a);
        for (int i = 0; i < n; i++) get_byte(i != n-1, rb[i]);
        bus_stop();
    endtask

    task automatic rd_ptr(input logic [7:0] p, input int n);
        logic a;
        bus_start();
        put_byte({ADDR, 1'b0}, a);
        put_byte(p, a);
        bus_start();
        put_byte({ADDR, 1'b1}, a);
        for (int i = 0; i < n; i++) get_byte(i != n-1, rb[i]);
        bus_stop();
    endtask

    task automatic pulse(input bit i_ev, input bit c_ev);
        int_evt = i_ev; crit_evt = c_ev; wq(1);
        int_evt = 1'b0; crit_evt = 1'b0; wq(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        void'($urandom(32'd20240611));
        wq(5); rst = 1'b0; wq(4);

        // reset state
        chk(cfg == 8'h00 && tlow == 16'h0 && thigh == 16'h0, "R2 reset regs", {cfg, tlow}, 0);
        chk(!int_f && !crit_f && !sda_oe, "R11 reset flags", {int_f, crit_f, sda_oe}, 0);

        // R2: pointer 0 at reset, direct read of temperature
        rd_direct(2);
        chk({rb[0], rb[1]} == 16'h1234, "R2 direct read temp", {rb[0], rb[1]}, 16'h1234);

        // R1: address mismatch
        bus_start();
        put_byte({ADDR ^ 7'h01, 1'b0}, a);
        chk(!a, "R1 mismatch nack", a, 0);
        put_byte(8'h01, a); put_byte(8'hFF, a);
        bus_stop();
        chk(cfg == 8'h00, "R1 mismatch ignored", cfg, 0);

        // R4: configuration single byte
        wr_reg(8'h01, 1, 16'h0050); m_cfg = 8'h50;
        chk(cfg == m_cfg, "R4 cfg write", cfg, m_cfg);

        // R4: partial limit write does not commit
        wr_reg(8'h02, 1, 16'h00AB);
        chk(tlow == 16'h0, "R4 partial limit", tlow, 0);
        wr_reg(8'h02, 2, 16'hC3A5); m_lo = 16'hC3A5;
        chk(tlow == m_lo, "R4 low limit write", tlow, m_lo);

        // R2: pointer masked to 2 bits -> high limit
        wr_reg(8'h07, 2, 16'h7E81); m_hi = 16'h7E81;
        chk(thigh == m_hi, "R2 pointer mask", thigh, m_hi);

        // R3: temperature write acked and ignored
        bus_start();
        put_byte({ADDR, 1'b0}, a); put_byte(8'h00, a); put_byte(8'hEE, a);
        chk(a, "R3 temp write acked", a, 1);
        put_byte(8'hDD, a); bus_stop();
        rd_direct(2);
        chk({rb[0], rb[1]} == temp, "R3 temp read-only", {rb[0], rb[1]}, temp);
        chk(tlow == m_lo && thigh == m_hi, "R3 limits untouched", tlow, m_lo);

        // R7 and R5: pointer set then repeated start, wide alternation
        rd_ptr(8'h03, 3);
        chk(rb[0] == m_hi[15:8] && rb[1] == m_hi[7:0], "R7 restart read", {rb[0], rb[1]}, m_hi);
        chk(rb[2] == m_hi[15:8], "R5 wide alternation", rb[2], m_hi[15:8]);
        // R2: pointer persists
        rd_direct(1);
        chk(rb[0] == m_hi[15:8], "R2 pointer persists", rb[0], m_hi[15:8]);
        // R5: cfg repeats
        rd_ptr(8'h01, 2);
        chk(rb[0] == m_cfg && rb[1] == m_cfg, "R5 cfg repeat", {rb[0], rb[1]}, {m_cfg, m_cfg});

        // R5: temperature snapshot during read; R6 ack then nack
        temp = 16'hA55A;
        rd_ptr(8'h00, 0);
        bus_start();
        put_byte({ADDR, 1'b1}, a);
        get_byte(1'b1, rb[0]);
        temp = 16'h0FF0;
        get_byte(1'b0, rb[1]);
        wq(Q);
        chk(!sda_oe, "R6 nack releases", sda_oe, 0);
        bus_stop();
        chk({rb[0], rb[1]} == 16'hA55A, "R5 snapshot", {rb[0], rb[1]}, 16'hA55A);
        chk(!sda_oe, "R8 stop releases", sda_oe, 0);

        // R11 and R9: comparator mode read does not clear
        wr_reg(8'h01, 1, 16'h0000); m_cfg = 8'h00;
        pulse(1'b1, 1'b0);
        chk(int_f, "R11 int set", int_f, 1);
        rd_direct(1);
        chk(int_f, "R9 comparator read keeps", int_f, 1);
        wr_reg(8'h01, 1, 16'h0002); m_cfg = 8'h02;
        rd_direct(1);
        chk(!int_f, "R9 interrupt read clears", int_f, 0);

        // R10: shutdown entry clears both, blocks events
        pulse(1'b1, 1'b1);
        chk(int_f && crit_f, "R11 both set", {int_f, crit_f}, 2'b11);
        wr_reg(8'h01, 1, 16'h0001); m_cfg = 8'h01;
        chk(!int_f && !crit_f, "R10 shutdown clears", {int_f, crit_f}, 0);
        pulse(1'b1, 1'b1);
        chk(!int_f && !crit_f, "R10 events blocked", {int_f, crit_f}, 0);
        wr_reg(8'h01, 1, 16'h0000); m_cfg = 8'h00;

        // random write / read-back
        for (int it = 0; it < 14; it++) begin
            int p;
            logic [15:0] v;
            logic [15:0] ew;
            p = 1 + int'($urandom % 3);
            v = 16'($urandom);
            if (p == 1) begin
                v[1:0] = 2'b00;
                wr_reg(8'(p), 1, v); m_cfg = v[7:0]; ew = {8'h00, m_cfg};
            end else begin
                wr_reg(8'(p), 2, v);
                if (p == 2) m_lo = v; else m_hi = v;
                ew = v;
            end
            rd_ptr(8'(p), 2);
            chk(rb[0] == exp_byte(ew, p != 1, 0) && rb[1] == exp_byte(ew, p != 1, 1),
                "R4 R5 random readback", {rb[0], rb[1]}, ew);
            chk(cfg == m_cfg && tlow == m_lo && thigh == m_hi, "R4 random ports", {cfg, tlow}, {m_cfg, m_lo});
        end
        for (int it = 0; it < 4; it++) begin
            temp = 16'($urandom);
            rd_ptr(8'h00, 2);
            chk({rb[0], rb[1]} == temp, "R3 random temp", {rb[0], rb[1]}, temp);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule